// File: doc/BRIEF.md
# Avionics Serial Word Transmitter

This block turns a 32-bit avionics data word into a stream of bipolar return-to-zero bit cells on two output wires. One wire means HI and the other means LO; when both are low the line is NULL, which carries no data. A host writes the four fields (label, source/destination code, data and sign/status) with a single-cycle load strobe. The block packs them into a word, works out the parity bit itself and sends the word. After every word it holds the line NULL for four bit times before the next word may start.

A system-clock enable `tick` marks half-cell boundaries at the fast rate. The `rate_lo` input divides it by `LS_RATIO` to give the slow rate. With a 200 kHz tick, the two rates are 100 kbit/s and 12.5 kbit/s. A one-word holding register lets the host queue the next word while the current one is on the line. `ready` shows that this holding register is free. Analog levels and line drivers are not part of the block.

Top module: `a429_tx`

## Requirements
- R1: Word bit 32 is set so that the 32-bit word holds an odd number of ones: an all-zero payload sends parity 1, and a payload with 31 ones sends parity 0.
- R2: Word bits 1–8 hold `label`, bits 9–10 hold `sdi`, bits 11–29 hold `data` and bits 30–31 hold `ssm`, each with its LSB at the lower word bit. Transmission order is label bit 7 down to label bit 0, then word bits 9 through 32 in ascending order.
- R3: Each bit cell drives `line_hi` (for a 1) or `line_lo` (for a 0) for its first half-cell and NULL for its second half-cell. The line never moves straight from HI to LO or from LO to HI.
- R4: One half-cell lasts one `tick` when `rate_lo`=0 and `LS_RATIO` ticks when `rate_lo`=1. The line changes only on a cycle in which `tick` is high.
- R5: A word queued behind another starts exactly four bit times (8 half-cells) after the end of the previous word's last bit cell. The NULL run between the last driven half-cell and the next word's first one is therefore 9 half-cells.
- R6: `ready` is low exactly while the holding register is occupied. A `ld` pulse while `ready` is low is ignored, and that word is never sent.
- R7: `line_hi` and `line_lo` are never high in the same cycle.
- R8: Under reset both lines are NULL and `ready` is high.
- R9: A word loaded while the transmitter is idle starts at the next half-cell boundary, and `ready` returns high once it has moved into the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Half-cell enable at the fast rate |
| rate_lo | input | 1 | 1 selects the slow rate |
| ld | input | 1 | Load strobe for the field inputs |
| label | input | 8 | Label field |
| sdi | input | 2 | Source/destination field |
| data | input | 19 | Data field |
| ssm | input | 2 | Sign/status field |
| ready | output | 1 | Holding register free |
| line_hi | output | 1 | Line driven HI |
| line_lo | output | 1 | Line driven LO |

## Verification
The bench decodes the two wires back into words and measures the HI/LO and NULL run lengths.

- A mixed-bit label/data pattern separates correct bit ordering from a reversed label or a reversed tail.
- An all-zero payload and an all-ones payload tell correct odd parity from even parity or a stuck parity bit.
- Two words queued back to back expose an off-by-one in the inter-word gap.
- A third load issued while the holding register is full must leave no trace on the line.
- A slow-rate word confirms that every half-cell stretches by the divide ratio.

// File: rtl/a429_tx.sv
module a429_tx #(
  parameter int LS_RATIO = 8,
  parameter int GAP_BITS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        rate_lo,
  input  logic        ld,
  input  logic [7:0]  label,
  input  logic [1:0]  sdi,
  input  logic [18:0] data,
  input  logic [1:0]  ssm,
  output logic        ready,
  output logic        line_hi,
  output logic        line_lo
);
  localparam int WBITS   = 32;
  localparam int IW      = $clog2(WBITS);
  localparam int HC_WORD = 2 * WBITS;
  localparam int HC_LAST = 2 * (WBITS + GAP_BITS) - 1;
  localparam int HW      = $clog2(HC_LAST + 1);
  localparam int DW      = (LS_RATIO > 1) ? $clog2(LS_RATIO) : 1;

  function automatic logic [WBITS-1:0] pack(input logic [7:0] lb, input logic [1:0] sd,
                                            input logic [18:0] dt, input logic [1:0] sm);
    logic [WBITS-1:0] o;
    for (int i = 0; i < 8; i++) o[i] = lb[7-i];
    o[9:8]   = sd;
    o[28:10] = dt;
    o[30:29] = sm;
    o[31]    = ~^{lb, sd, dt, sm};
    return o;
  endfunction

  logic [DW-1:0]    div;
  logic [WBITS-1:0] hold_w, sh;
  logic             hold_v, tx_v;
  logic [HW-1:0]    hcnt;

  wire step    = tick && (!rate_lo || div == DW'(LS_RATIO - 1));
  wire at_end  = hcnt == HW'(HC_LAST);
  wire take    = step && hold_v && (!tx_v || at_end);
  wire drive   = tx_v && hcnt < HW'(HC_WORD) && !hcnt[0];
  wire [IW-1:0] bidx = hcnt[IW:1];

  assign ready   = !hold_v;
  assign line_hi = drive && sh[bidx];
  assign line_lo = drive && !sh[bidx];

  always_ff @(posedge clk) begin
    if (!rst_n) div <= '0;
    else if (tick) div <= (!rate_lo || div == DW'(LS_RATIO - 1)) ? '0 : div + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_w <= '0;
    end else if (ld && !hold_v) begin
      hold_v <= 1'b1;
      hold_w <= pack(label, sdi, data, ssm);
    end else if (take) begin
      hold_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_v <= 1'b0;
      hcnt <= '0;
      sh   <= '0;
    end else if (take) begin
      tx_v <= 1'b1;
      hcnt <= '0;
      sh   <= hold_w;
    end else if (step && tx_v) begin
      if (at_end) tx_v <= 1'b0;
      else hcnt <= hcnt + 1'b1;
    end
  end
endmodule

// File: rtl/a429_tx_chk.sv
module a429_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic ld,
  input logic ready,
  input logic line_hi,
  input logic line_lo
);
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n) !(line_hi && line_lo));
  a_r3_rz_hi: assert property (@(posedge clk) disable iff (!rst_n) line_hi |=> !line_lo);
  a_r3_rz_lo: assert property (@(posedge clk) disable iff (!rst_n) line_lo |=> !line_hi);
  a_r4_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable({line_hi, line_lo}));
  a_r6_ready_drop: assert property (@(posedge clk) disable iff (!rst_n) (ready && ld) |=> !ready);
endmodule

bind a429_tx a429_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ld(ld),
  .ready(ready), .line_hi(line_hi), .line_lo(line_lo)
);

// File: tb/a429_tx_bench.sv
module a429_tx_bench;
  logic clk = 0, rst_n = 0, tick = 1, rate_lo = 0, ld = 0;
  logic [7:0] label = 0;
  logic [1:0] sdi = 0, ssm = 0;
  logic [18:0] data = 0;
  logic ready, line_hi, line_lo;
  int checks = 0, errors = 0, cyc = 0;

  a429_tx u_a429_tx (.*);

  always #2.5 clk = ~clk;

  int nb = 0, nwords = 0, act_run = 0, null_run = 0, last_gap = 0, both_err = 0;
  int act_min = 9999, act_max = 0, nul_min = 9999, nul_max = 0;
  logic prev_act = 0;
  logic [31:0] rxw = 0;
  logic [31:0] words [0:15];

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (line_hi && line_lo) both_err++;
      if ((line_hi || line_lo) && !prev_act) begin
        if (nb == 0) last_gap = null_run;
        else begin
          if (null_run < nul_min) nul_min = null_run;
          if (null_run > nul_max) nul_max = null_run;
        end
        rxw[nb] = line_hi;
        nb++;
        act_run = 0;
      end
      if (!(line_hi || line_lo) && prev_act) begin
        if (act_run < act_min) act_min = act_run;
        if (act_run > act_max) act_max = act_run;
        if (nb == 32) begin
          if (nwords < 16) words[nwords] = rxw;
          nwords++;
          nb = 0;
        end
      end
      if (line_hi || line_lo) begin act_run++; null_run = 0; end
      else null_run++;
      prev_act = line_hi || line_lo;
    end
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input logic [7:0] lb, input logic [1:0] sd,
                                              input logic [18:0] dt, input logic [1:0] sm);
    logic [31:0] w, t;
    int ones = 0;
    w = {1'b0, sm, dt, sd, lb};
    for (int i = 0; i < 31; i++) ones += w[i];
    w[31] = (ones % 2 == 0);
    for (int i = 0; i < 8; i++) t[i] = w[7-i];
    for (int i = 8; i < 32; i++) t[i] = w[i];
    return t;
  endfunction

  task automatic clr();
    nb = 0; nwords = 0;
    act_min = 9999; act_max = 0; nul_min = 9999; nul_max = 0;
  endtask

  task automatic load(input logic [7:0] lb, input logic [1:0] sd,
                      input logic [18:0] dt, input logic [1:0] sm);
    @(negedge clk);
    label = lb; sdi = sd; data = dt; ssm = sm; ld = 1;
    @(negedge clk);
    ld = 0;
  endtask

  task automatic wait_words(input int n);
    for (int i = 0; i < 20000 && nwords < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R8 ready", ready, 1);
    check("R8 lines", {line_hi, line_lo}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R8 ready after release", ready, 1);
    check("R7 lines idle", {line_hi, line_lo}, 0);
  endtask

  task automatic t_single();
    clr();
    load(8'h98, 2'b01, 19'h5A5A5, 2'b11);
    @(negedge clk);
    check("R9 ready after shift", ready, 1);
    wait_words(1);
    repeat (20) @(negedge clk);
    check("R2 word order", nwords == 1 ? words[0] : 32'hx, expect_word(8'h98, 2'b01, 19'h5A5A5, 2'b11));
    check("R3 drive half width", {act_min[15:0], act_max[15:0]}, {16'd1, 16'd1});
    check("R4 null half width", {nul_min[15:0], nul_max[15:0]}, {16'd1, 16'd1});
  endtask

  task automatic t_back_to_back();
    clr();
    load(8'h35, 2'b10, 19'h7_0F0F, 2'b01);
    wait (ready);
    load(8'hC1, 2'b00, 19'h0_1234, 2'b10);
    check("R6 ready low while queued", ready, 0);
    wait_words(2);
    repeat (20) @(negedge clk);
    check("R9 first word", words[0], expect_word(8'h35, 2'b10, 19'h7_0F0F, 2'b01));
    check("R2 second word", words[1], expect_word(8'hC1, 2'b00, 19'h0_1234, 2'b10));
    check("R5 gap half-cells", last_gap, 9);
  endtask

  task automatic t_full_ignore();
    clr();
    load(8'h11, 2'b11, 19'h2_2222, 2'b00);
    wait (ready);
    load(8'h22, 2'b01, 19'h3_3333, 2'b01);
    check("R6 ready low full", ready, 0);
    load(8'hFF, 2'b11, 19'h7_FFFF, 2'b11);
    wait_words(2);
    repeat (200) @(negedge clk);
    check("R6 ignored load count", nwords, 2);
    check("R6 second word intact", words[1], expect_word(8'h22, 2'b01, 19'h3_3333, 2'b01));
  endtask

  task automatic t_slow_zero();
    clr();
    rate_lo = 1;
    load(8'h00, 2'b00, 19'h0, 2'b00);
    wait_words(1);
    repeat (100) @(negedge clk);
    check("R1 zero payload parity", words[0], expect_word(8'h00, 2'b00, 19'h0, 2'b00));
    check("R1 parity bit one", words[0][31], 1);
    check("R4 slow half widths", {act_max[15:0], nul_min[15:0]}, {16'd8, 16'd8});
    rate_lo = 0;
  endtask

  task automatic t_ones();
    clr();
    load(8'hFF, 2'b11, 19'h7_FFFF, 2'b11);
    wait_words(1);
    repeat (20) @(negedge clk);
    check("R1 all-ones word", words[0], expect_word(8'hFF, 2'b11, 19'h7_FFFF, 2'b11));
    check("R1 parity bit zero", words[0][31], 0);
  endtask

  task automatic t_gated_tick();
    clr();
    load(8'hA5, 2'b10, 19'h1_5555, 2'b10);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      tick = (i % 3 == 0);
    end
    tick = 1;
    wait_words(1);
    repeat (20) @(negedge clk);
    check("R4 sparse tick word", words[0], expect_word(8'hA5, 2'b10, 19'h1_5555, 2'b10));
    check("R3 sparse tick half width", act_max, 3);
  endtask

  initial begin
    t_reset();
    t_single();
    t_back_to_back();
    t_full_ignore();
    t_slow_zero();
    t_ones();
    t_gated_tick();
    check("R7 no HI and LO together", both_err, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule